// File: doc/BRIEF.md
# Masked Compare-and-Swap Engine

This block sits between an upstream requester and a downstream bus and turns one ordinary upstream read into an atomic read-modify-write. A host arms the engine through a small register port. It sets a trigger word address, an address-space select, a bit mask, a compare word and a swap word.

When an upstream read lands on the armed word, the engine locks the downstream bus and reads the word. It tests only the masked bit positions against the compare word. If they all agree, it writes back a merged word before it drops the lock: swap bits where the mask is set, and read bits everywhere else. The requester always gets the word exactly as it was read. Reads that do not hit the armed word pass through as plain, unlocked reads.

A second mode runs a locked, address-only access with no write phase. A downstream error ends any engine cycle and leaves a sticky flag, which the host clears by writing 1.

Top module: `cas_engine`

## Requirements
- R1: With the control register at zero, no upstream read is intercepted. Every read becomes a single unlocked downstream read, and no downstream write occurs.
- R2: Control bits [1:0] select the mode. Value 1 is read-modify-write. Value 2 is address-only: one locked downstream read flagged by `dn_aonly`, with no write phase. Values 0 and 3 intercept nothing.
- R3: Control bit 2 selects the space of the trigger address (1 = IO, 0 = memory). A read hits only when `up_io` equals this bit.
- R4: A hit compares `up_addr[AW-1:2]` with the trigger address. Address bits [1:0] play no part, and downstream addresses are word aligned.
- R5: In read-modify-write mode, the write phase occurs exactly when `((read ^ cmp) & mask) == 0`. Differences outside the mask never block it.
- R6: The written word equals `(read & ~mask) | (swap & mask)`.
- R7: `dn_lock` is high from the first read cycle of a hit through the last write cycle. With the one-cycle-latency bus, that is 4 cycles on a match and 2 cycles without a match or in address-only mode. It is low for plain reads, and every downstream write happens under lock.
- R8: The upstream read data is the original word read downstream, whether or not a swap happened.
- R9: `dn_err` in either phase ends the cycle, returns `up_err` = 1 and drops the lock. For intercepted cycles only, it also sets the sticky flag, which appears as status bit 0 and on `err_flag`. Writing 1 to status bit 0 clears it, and writing 0 has no effect.
- R10: Register map by `cfg_addr`: 0 control, 1 trigger address, 2 mask, 3 compare, 4 swap, 5 status. `cfg_rdata` returns the selected register combinationally, and all registers reset to zero.
- R11: `up_req` is held until `up_ack`, which is a one-cycle pulse carrying `up_rdata`/`up_err`. `dn_req` is held until `dn_ack` or `dn_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Selected register value |
| up_req | input | 1 | Upstream read request, held until acknowledged |
| up_addr | input | AW | Upstream byte address |
| up_io | input | 1 | Upstream space, 1 = IO |
| up_ack | output | 1 | Upstream completion pulse |
| up_err | output | 1 | Upstream completion with error |
| up_rdata | output | DW | Original word read |
| dn_req | output | 1 | Downstream request |
| dn_we | output | 1 | Downstream write phase |
| dn_lock | output | 1 | Downstream bus lock |
| dn_aonly | output | 1 | Address-only access marker |
| dn_io | output | 1 | Downstream space, 1 = IO |
| dn_addr | output | AW | Downstream word-aligned address |
| dn_wdata | output | DW | Downstream write data |
| dn_rdata | input | DW | Downstream read data |
| dn_ack | input | 1 | Downstream completion |
| dn_err | input | 1 | Downstream error completion |
| err_flag | output | 1 | Sticky error flag |

## Verification
The hardest states to reach are downstream errors that strike in the middle of a locked sequence, in particular during the write phase after the lock has already been held through a successful read. The bench's downstream model has separate per-phase error injection switches. These switches let it fail only the write of a matching swap, or only the read. The bench then checks three things through the ports: the lock dropped, memory is unchanged, and the sticky flag behaves as R9 requires. Partial-mask cases are built from chosen memory contents so that bits outside the mask differ while the masked bits agree.

// File: rtl/cas_pkg.sv
package cas_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} cas_state_e;

    localparam logic [1:0] MODE_RMW   = 2'd1;
    localparam logic [1:0] MODE_AONLY = 2'd2;

    localparam logic [2:0] REG_CTRL = 3'd0;
    localparam logic [2:0] REG_TRIG = 3'd1;
    localparam logic [2:0] REG_MASK = 3'd2;
    localparam logic [2:0] REG_CMP  = 3'd3;
    localparam logic [2:0] REG_SWAP = 3'd4;
    localparam logic [2:0] REG_STAT = 3'd5;
endpackage

// File: rtl/cas_regs.sv
module cas_regs
    import cas_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          err_set,
    output logic [1:0]    mode,
    output logic          io_sel,
    output logic [AW-1:0] trig,
    output logic [DW-1:0] mask,
    output logic [DW-1:0] cmp,
    output logic [DW-1:0] swap,
    output logic          err
);
    typedef struct packed {
        logic [1:0]    mode;
        logic          io;
        logic [AW-1:0] trig;
        logic [DW-1:0] mask;
        logic [DW-1:0] cmp;
        logic [DW-1:0] swap;
        logic          err;
    } regs_t;

    regs_t r_d, r_q;
    logic  clr_req;

    assign clr_req = cfg_we && (cfg_addr == REG_STAT) && cfg_wdata[0];

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            case (cfg_addr)
                REG_CTRL: begin
                    r_d.mode = cfg_wdata[1:0];
                    r_d.io   = cfg_wdata[2];
                end
                REG_TRIG: r_d.trig = cfg_wdata[AW-1:0];
                REG_MASK: r_d.mask = cfg_wdata;
                REG_CMP:  r_d.cmp  = cfg_wdata;
                REG_SWAP: r_d.swap = cfg_wdata;
                REG_STAT: if (cfg_wdata[0]) r_d.err = 1'b0;
                default: ;
            endcase
        end
        if (err_set) r_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            REG_CTRL: cfg_rdata[2:0] = {r_q.io, r_q.mode};
            REG_TRIG: cfg_rdata[AW-1:0] = r_q.trig;
            REG_MASK: cfg_rdata = r_q.mask;
            REG_CMP:  cfg_rdata = r_q.cmp;
            REG_SWAP: cfg_rdata = r_q.swap;
            REG_STAT: cfg_rdata[0] = r_q.err;
            default: ;
        endcase
    end

    assign mode   = r_q.mode;
    assign io_sel = r_q.io;
    assign trig   = r_q.trig;
    assign mask   = r_q.mask;
    assign cmp    = r_q.cmp;
    assign swap   = r_q.swap;
    assign err    = r_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr_req) |=> err);  // R9
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !err_set) |=> !err);  // R9
endmodule

// File: rtl/cas_match.sv
module cas_match
    import cas_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [1:0]    mode,
    input  logic          io_sel,
    input  logic [AW-1:0] trig,
    input  logic [AW-1:0] up_addr,
    input  logic          up_io,
    input  logic [DW-1:0] rd_word,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] cmp,
    input  logic [DW-1:0] swap,
    output logic          hit,
    output logic          aonly,
    output logic          equal,
    output logic [DW-1:0] merged
);
    logic armed;

    assign armed  = (mode == MODE_RMW) || (mode == MODE_AONLY);
    assign hit    = armed && (io_sel == up_io) && (up_addr[AW-1:2] == trig[AW-1:2]);
    assign aonly  = (mode == MODE_AONLY);
    assign equal  = ((rd_word ^ cmp) & mask) == '0;
    assign merged = (rd_word & ~mask) | (swap & mask);
endmodule

// File: rtl/cas_engine.sv
module cas_engine
    import cas_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          up_req,
    input  logic [AW-1:0] up_addr,
    input  logic          up_io,
    output logic          up_ack,
    output logic          up_err,
    output logic [DW-1:0] up_rdata,
    output logic          dn_req,
    output logic          dn_we,
    output logic          dn_lock,
    output logic          dn_aonly,
    output logic          dn_io,
    output logic [AW-1:0] dn_addr,
    output logic [DW-1:0] dn_wdata,
    input  logic [DW-1:0] dn_rdata,
    input  logic          dn_ack,
    input  logic          dn_err,
    output logic          err_flag
);
    typedef struct packed {
        cas_state_e    st;
        logic          hit;
        logic          aonly;
        logic          io;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          ack;
        logic          uerr;
    } fsm_t;

    fsm_t f_d, f_q;

    logic [1:0]    mode;
    logic          io_sel, err_set, hit, aonly, equal;
    logic [AW-1:0] trig;
    logic [DW-1:0] mask, cmp, swap, merged;

    cas_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .err_set(err_set),
        .mode(mode), .io_sel(io_sel), .trig(trig), .mask(mask), .cmp(cmp),
        .swap(swap), .err(err_flag)
    );

    cas_match #(.AW(AW), .DW(DW)) u_match (
        .mode(mode), .io_sel(io_sel), .trig(trig), .up_addr(up_addr),
        .up_io(up_io), .rd_word(dn_rdata), .mask(mask), .cmp(cmp),
        .swap(swap), .hit(hit), .aonly(aonly), .equal(equal), .merged(merged)
    );

    always_comb begin
        f_d      = f_q;
        f_d.ack  = 1'b0;
        f_d.uerr = 1'b0;
        err_set  = 1'b0;
        case (f_q.st)
            ST_IDLE: begin
                if (up_req && !f_q.ack) begin
                    f_d.st    = ST_RD;
                    f_d.hit   = hit;
                    f_d.aonly = hit && aonly;
                    f_d.io    = up_io;
                    f_d.addr  = {up_addr[AW-1:2], 2'b00};
                end
            end
            ST_RD: begin
                if (dn_err) begin
                    f_d.st    = ST_IDLE;
                    f_d.ack   = 1'b1;
                    f_d.uerr  = 1'b1;
                    f_d.rdata = dn_rdata;
                    err_set   = f_q.hit;
                end else if (dn_ack) begin
                    f_d.rdata = dn_rdata;
                    f_d.wdata = merged;
                    if (f_q.hit && !f_q.aonly && equal) begin
                        f_d.st = ST_WR;
                    end else begin
                        f_d.st  = ST_IDLE;
                        f_d.ack = 1'b1;
                    end
                end
            end
            ST_WR: begin
                if (dn_err || dn_ack) begin
                    f_d.st   = ST_IDLE;
                    f_d.ack  = 1'b1;
                    f_d.uerr = dn_err;
                    err_set  = dn_err;
                end
            end
            default: f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '{st: ST_IDLE, default: '0};
        else        f_q <= f_d;
    end

    assign dn_req   = (f_q.st != ST_IDLE);
    assign dn_we    = (f_q.st == ST_WR);
    assign dn_lock  = f_q.hit && (f_q.st != ST_IDLE);
    assign dn_aonly = f_q.aonly && (f_q.st == ST_RD);
    assign dn_io    = f_q.io;
    assign dn_addr  = f_q.addr;
    assign dn_wdata = f_q.wdata;
    assign up_ack   = f_q.ack;
    assign up_err   = f_q.uerr;
    assign up_rdata = f_q.rdata;

    AST_LOCK_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dn_lock |-> dn_req);  // R7
    AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_we) |-> dn_lock);  // R7
    AST_AONLY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_aonly |=> !dn_we);  // R2
    AST_MERGE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_we) |-> (((dn_wdata ^ $past(swap)) & $past(mask)) == '0));  // R6
    AST_MERGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_we) |-> (((dn_wdata ^ $past(dn_rdata)) & ~$past(mask)) == '0));  // R6
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack |=> !up_ack);  // R11
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ack && !dn_err) |=> dn_req);  // R11
endmodule

// File: tb/sim_cas_engine.sv
`timescale 1ns/1ps
module sim_cas_engine;
    localparam int AW = 32;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic          up_req = 1'b0;
    logic [AW-1:0] up_addr = '0;
    logic          up_io = 1'b0;
    logic          up_ack, up_err;
    logic [DW-1:0] up_rdata;
    logic          dn_req, dn_we, dn_lock, dn_aonly, dn_io;
    logic [AW-1:0] dn_addr;
    logic [DW-1:0] dn_wdata;
    logic [DW-1:0] dn_rdata = '0;
    logic          dn_ack = 1'b0, dn_err = 1'b0;
    logic          err_flag;

    cas_engine #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .up_req(up_req),
        .up_addr(up_addr), .up_io(up_io), .up_ack(up_ack), .up_err(up_err),
        .up_rdata(up_rdata), .dn_req(dn_req), .dn_we(dn_we), .dn_lock(dn_lock),
        .dn_aonly(dn_aonly), .dn_io(dn_io), .dn_addr(dn_addr),
        .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_ack(dn_ack),
        .dn_err(dn_err), .err_flag(err_flag)
    );

    // downstream memory model, one-cycle latency
    logic [31:0] mem [16];
    logic        ld = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [31:0] ld_val = '0;
    logic        inj_rd = 1'b0, inj_wr = 1'b0;
    int          wr_cnt = 0;

    always @(posedge clk) begin
        if (ld) mem[ld_idx] <= ld_val;
        if (dn_req && !dn_ack && !dn_err) begin
            dn_rdata <= mem[dn_addr[5:2]];
            if (dn_we ? inj_wr : inj_rd) dn_err <= 1'b1;
            else begin
                dn_ack <= 1'b1;
                if (dn_we) begin
                    mem[dn_addr[5:2]] <= dn_wdata;
                    wr_cnt <= wr_cnt + 1;
                end
            end
        end else begin
            dn_ack <= 1'b0;
            dn_err <= 1'b0;
        end
    end

    int nchk = 0, nfail = 0;
    int lk_cnt = 0, ao_cnt = 0, lock_viol = 0;
    logic [DW:0] exp_q[$];
    string       tag_q[$];

    // monitor / scoreboard
    always @(negedge clk) begin
        if (dn_lock) lk_cnt++;
        if (dn_aonly) ao_cnt++;
        if (dn_req && dn_we && !dn_lock) lock_viol++;
        if (rst_n && up_ack) begin
            nchk++;
            if (exp_q.size() == 0) begin
                nfail++;
                $display("FAIL R11 unexpected up_ack act=%h exp=none", up_rdata);
            end else begin
                logic [DW:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({up_err, up_rdata} !== e) begin
                    nfail++;
                    $display("FAIL %s upstream act=%h exp=%h", t, {up_err, up_rdata}, e);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1 v = cfg_rdata;
    endtask

    task automatic ld_mem(input logic [3:0] i, input logic [31:0] v);
        @(negedge clk);
        ld = 1'b1; ld_idx = i; ld_val = v;
        @(negedge clk);
        ld = 1'b0;
    endtask

    task automatic up_rd(input logic [31:0] a, input logic io, input logic [31:0] exp,
                         input logic eerr, input string tag);
        @(negedge clk);
        exp_q.push_back({eerr, exp});
        tag_q.push_back(tag);
        up_req = 1'b1; up_addr = a; up_io = io;
        do @(negedge clk); while (!up_ack);
        up_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R11 watchdog expired act=%h exp=%h", 32'h0, 32'h1);
        summary();
    end

    initial begin
        logic [31:0] v;
        int lk0, wr0, ao0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state (R10, R11)
        chk(up_ack == 0 && dn_req == 0, "R11 reset idle", {30'h0, up_ack, dn_req}, 32'h0);
        chk(err_flag == 0, "R9 reset flag", {31'h0, err_flag}, 32'h0);
        cfg_rd(3'd0, v); chk(v == 0, "R10 reset ctrl", v, 32'h0);

        ld_mem(4'd0, 32'hA5A5_1234);
        ld_mem(4'd1, 32'h0F0F_0F0F);
        ld_mem(4'd2, 32'h1111_2222);

        // R1 disabled: plain read
        lk0 = lk_cnt; wr0 = wr_cnt;
        up_rd(32'h0, 1'b0, 32'hA5A5_1234, 1'b0, "R1 plain read");
        chk(lk_cnt == lk0 && wr_cnt == wr0, "R1 no lock no write", lk_cnt - lk0 + wr_cnt - wr0, 0);

        // arm RMW, memory space
        cfg_wr(3'd1, 32'h0);
        cfg_wr(3'd2, 32'h0000_FFFF);
        cfg_wr(3'd3, 32'h0000_1234);
        cfg_wr(3'd4, 32'h0000_BEEF);
        cfg_wr(3'd0, 32'h1);
        cfg_rd(3'd0, v); chk(v == 32'h1, "R10 ctrl readback", v, 32'h1);
        cfg_rd(3'd2, v); chk(v == 32'h0000_FFFF, "R10 mask readback", v, 32'h0000_FFFF);

        // R4 low bits ignored, R5 match, R8 original value, R7 lock 4 cycles
        lk0 = lk_cnt; wr0 = wr_cnt;
        up_rd(32'h1, 1'b0, 32'hA5A5_1234, 1'b0, "R8 original on swap");
        chk(wr_cnt == wr0 + 1, "R5 match writes", wr_cnt - wr0, 1);
        chk(lk_cnt - lk0 == 4, "R7 lock span match", lk_cnt - lk0, 4);
        chk(dn_lock == 0, "R7 lock released", {31'h0, dn_lock}, 0);
        cfg_wr(3'd0, 32'h0);
        up_rd(32'h0, 1'b0, 32'hA5A5_BEEF, 1'b0, "R6 merged word");

        // no match, low bits 3
        cfg_wr(3'd0, 32'h1);
        lk0 = lk_cnt; wr0 = wr_cnt;
        up_rd(32'h3, 1'b0, 32'hA5A5_BEEF, 1'b0, "R8 no match value");
        chk(wr_cnt == wr0, "R5 mismatch no write", wr_cnt - wr0, 0);
        chk(lk_cnt - lk0 == 2, "R7 lock span mismatch", lk_cnt - lk0, 2);

        // other address not intercepted
        lk0 = lk_cnt;
        up_rd(32'h4, 1'b0, 32'h0F0F_0F0F, 1'b0, "R4 other word");
        chk(lk_cnt == lk0, "R4 other word unlocked", lk_cnt - lk0, 0);

        // R3 IO space
        cfg_wr(3'd2, 32'hFFFF_FFFF);
        cfg_wr(3'd3, 32'hA5A5_BEEF);
        cfg_wr(3'd4, 32'h55AA_55AA);
        cfg_wr(3'd0, 32'h5);
        lk0 = lk_cnt; wr0 = wr_cnt;
        up_rd(32'h0, 1'b0, 32'hA5A5_BEEF, 1'b0, "R3 wrong space");
        chk(lk_cnt == lk0 && wr_cnt == wr0, "R3 mem read not intercepted", lk_cnt - lk0, 0);
        up_rd(32'h0, 1'b1, 32'hA5A5_BEEF, 1'b0, "R3 io hit");
        chk(wr_cnt == wr0 + 1, "R3 io swap", wr_cnt - wr0, 1);
        cfg_wr(3'd0, 32'h0);
        up_rd(32'h0, 1'b0, 32'h55AA_55AA, 1'b0, "R6 full mask swap");

        // R2 address-only and mode 3
        cfg_wr(3'd1, 32'h8);
        cfg_wr(3'd3, 32'h1111_2222);
        cfg_wr(3'd0, 32'h2);
        lk0 = lk_cnt; wr0 = wr_cnt; ao0 = ao_cnt;
        up_rd(32'h8, 1'b0, 32'h1111_2222, 1'b0, "R2 addr-only data");
        chk(ao_cnt - ao0 == 2 && lk_cnt - lk0 == 2, "R2 aonly locked", ao_cnt - ao0, 2);
        chk(wr_cnt == wr0, "R2 aonly no write", wr_cnt - wr0, 0);
        cfg_wr(3'd0, 32'h3);
        lk0 = lk_cnt; wr0 = wr_cnt;
        up_rd(32'h8, 1'b0, 32'h1111_2222, 1'b0, "R2 mode3 plain");
        chk(lk_cnt == lk0 && wr_cnt == wr0, "R2 mode3 no intercept", lk_cnt - lk0, 0);

        // R5/R6 partial mask: outside bits differ, masked nibble agrees
        cfg_wr(3'd1, 32'h4);
        cfg_wr(3'd2, 32'h0000_00F0);
        cfg_wr(3'd3, 32'h0000_0000);
        cfg_wr(3'd4, 32'hFFFF_FFA0);
        cfg_wr(3'd0, 32'h1);
        wr0 = wr_cnt;
        up_rd(32'h4, 1'b0, 32'h0F0F_0F0F, 1'b0, "R5 partial match");
        chk(wr_cnt == wr0 + 1, "R5 partial mask writes", wr_cnt - wr0, 1);
        cfg_wr(3'd3, 32'h0000_0010);
        wr0 = wr_cnt;
        up_rd(32'h4, 1'b0, 32'h0F0F_0FAF, 1'b0, "R6 partial merge");
        chk(wr_cnt == wr0, "R5 masked bit differs", wr_cnt - wr0, 0);

        // R9 write-phase error
        cfg_wr(3'd1, 32'h0);
        cfg_wr(3'd2, 32'h0);
        cfg_wr(3'd4, 32'h1234_5678);
        inj_wr = 1'b1;
        wr0 = wr_cnt;
        up_rd(32'h0, 1'b0, 32'h55AA_55AA, 1'b1, "R9 write error");
        inj_wr = 1'b0;
        chk(dn_lock == 0 && wr_cnt == wr0, "R9 lock dropped no write", {31'h0, dn_lock}, 0);
        chk(err_flag == 1, "R9 flag set", {31'h0, err_flag}, 1);
        cfg_wr(3'd5, 32'h0);
        cfg_rd(3'd5, v); chk(v == 1, "R9 write 0 keeps flag", v, 1);
        cfg_wr(3'd5, 32'h1);
        cfg_rd(3'd5, v); chk(v == 0, "R9 W1C clears", v, 0);

        // R9 read-phase error
        inj_rd = 1'b1;
        up_rd(32'h0, 1'b0, 32'h55AA_55AA, 1'b1, "R9 read error");
        chk(err_flag == 1, "R9 read err flag", {31'h0, err_flag}, 1);
        cfg_wr(3'd5, 32'h1);
        cfg_wr(3'd0, 32'h0);
        up_rd(32'h0, 1'b0, 32'h55AA_55AA, 1'b1, "R9 plain read error");
        inj_rd = 1'b0;
        chk(err_flag == 0, "R9 plain err not sticky", {31'h0, err_flag}, 0);

        chk(lock_viol == 0, "R7 writes under lock", lock_viol, 0);
        chk(exp_q.size() == 0, "R11 all acks seen", exp_q.size(), 0);
        summary();
    end
endmodule